// File: doc/BRIEF.md
# Boot ROM Region Routing Decoder

This block sits between the processor's request path and two downstream targets: a flash device on the local memory bus and the PCI host bridge. It watches the top 16 MB of the address space (0xFF00_0000 to 0xFFFF_FFFF), the boot ROM window, and decides for each accepted request which target serves it. It also decides which local ROM chip-select is raised. A boot-location strap, captured when reset is released, places the whole window either locally or on PCI. When the window is on PCI, a software-writable split-enable bit can bring the lower 8 MB back to the local flash under a second chip-select, so performance-critical code runs from the local bus while boot firmware stays behind the bridge.

Two width straps are captured at the same moment and set the local flash data-path width, which is shown on a steady output. Each request is accepted through a valid/ready handshake and registered. On the next cycle it is presented on exactly one downstream port, where it holds until that port is ready. Addresses outside the window are flagged as a miss and forwarded to the PCI port unchanged.

Top module: `boot_rom_router`

## Requirements
- R1: The boot-location strap is captured on the first rising clock edge with `rst_n` high. Later changes on the strap pins do not alter routing until the next reset.
- R2: With the boot strap at 1 (PCI) and split-enable at 0, every window address is routed to the PCI port. `route` is 2'b10 and both chip-selects are low.
- R3: With the boot strap at 1 and split-enable at 1, addresses 0xFF00_0000..0xFF7F_FFFF go to the local port with `loc_cs_split` high and `route` 2'b01. Addresses 0xFF80_0000..0xFFFF_FFFF go to the PCI port with `route` 2'b10.
- R4: With the boot strap at 0 (local), every window address goes to the local port with `loc_cs_boot` high and `route` 2'b01, whatever the split-enable value.
- R5: An address whose upper eight bits are not all ones gives `route` 2'b00, `miss` high and both chip-selects low. The request is forwarded on the PCI port.
- R6: `width_32` is 1 (32-bit) if either width strap is high at capture, and 0 (64-bit) if both are low. It keeps that value until the next reset and reads 0 during reset.
- R7: A request accepted on one edge appears on exactly one downstream valid after that edge. Valid and address hold until the port's ready is seen, and `req_ready` stays low while the request is pending and during reset.
- R8: Split-enable resets to 0. A write on the same edge that accepts a request does not affect that request's route, but it does affect later requests.
- R9: The downstream address equals the accepted request address on every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_boot_pci | input | 1 | Boot-location strap: 1 = ROM window on PCI, 0 = local |
| strap_width | input | 2 | Width straps: any bit high = 32-bit, both low = 64-bit |
| cfg_we | input | 1 | Write strobe for the split-enable bit |
| cfg_split_wdata | input | 1 | New split-enable value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Request address |
| loc_valid | output | 1 | Request valid on the local flash port |
| loc_ready | input | 1 | Local port accepts the request |
| loc_addr | output | ADDR_W | Local port address |
| loc_cs_boot | output | 1 | Boot ROM chip-select (strap-local mode) |
| loc_cs_split | output | 1 | Second ROM chip-select (split mode) |
| pci_valid | output | 1 | Request valid on the PCI port |
| pci_ready | input | 1 | PCI port accepts the request |
| pci_addr | output | ADDR_W | PCI port address |
| route | output | 2 | Route of the pending request: 00 none, 01 local, 10 PCI |
| miss | output | 1 | Pending request lies outside the ROM window |
| width_32 | output | 1 | Captured local data-path width: 1 = 32-bit, 0 = 64-bit |

## Verification
The hardest case to reach from the ports is a split-enable write that lands on the same edge as a request acceptance. The old setting must govern that request and the new one the request after it. The bench drives `cfg_we` and `req_valid` together in the same cycle, with a lower-half address, so the two settings give different routes. It then issues a second lower-half request and checks that the route changes. The bench also flips the strap pins right after capture, then sweeps window-boundary addresses and downstream stall lengths, which shows that the captured strap values and held requests survive activity on those pins.

// File: rtl/brr_pkg.sv
package brr_pkg;

  typedef enum logic [1:0] {
    RT_NONE  = 2'b00,
    RT_LOCAL = 2'b01,
    RT_PCI   = 2'b10
  } route_e;

  typedef struct packed {
    route_e route;
    logic   miss;
    logic   cs_boot;
    logic   cs_split;
  } decision_t;

endpackage

// File: rtl/brr_strap_latch.sv
module brr_strap_latch #(
  parameter int WID_STRAPS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_boot_pci,
  input  logic [WID_STRAPS-1:0] strap_width,
  output logic                  captured,
  output logic                  boot_pci,
  output logic                  width_32
);

  logic captured_d, boot_d, wid_d;
  logic capture_en;

  assign capture_en = !captured;

  always_comb begin
    captured_d = captured;
    boot_d     = boot_pci;
    wid_d      = width_32;
    if (capture_en) begin
      captured_d = 1'b1;
      boot_d     = strap_boot_pci;
      wid_d      = |strap_width;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      boot_pci <= 1'b0;
      width_32 <= 1'b0;
    end else if (capture_en) begin
      captured <= captured_d;
      boot_pci <= boot_d;
      width_32 <= wid_d;
    end
  end

endmodule

// File: rtl/brr_split_reg.sv
module brr_split_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic split_en
);

  logic split_d;

  always_comb begin
    split_d = split_en;
    if (wr_en) split_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     split_en <= 1'b0;
    else if (wr_en) split_en <= split_d;
  end

endmodule

// File: rtl/brr_window_decode.sv
module brr_window_decode
  import brr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 24
) (
  input  logic [ADDR_W-WIN_LOG2:0] addr_hi,
  input  logic                     boot_pci,
  input  logic                     split_en,
  output decision_t                dec
);

  localparam int TAG_W = ADDR_W - WIN_LOG2;

  logic [TAG_W-1:0] tag;
  logic             upper_half;
  logic             in_win;

  assign tag        = addr_hi[TAG_W:1];
  assign upper_half = addr_hi[0];
  assign in_win     = (tag == {TAG_W{1'b1}});

  always_comb begin
    dec = '{route: RT_NONE, miss: 1'b0, cs_boot: 1'b0, cs_split: 1'b0};
    if (!in_win) begin
      dec.miss = 1'b1;
    end else if (!boot_pci) begin
      dec.route   = RT_LOCAL;
      dec.cs_boot = 1'b1;
    end else if (split_en && !upper_half) begin
      dec.route    = RT_LOCAL;
      dec.cs_split = 1'b1;
    end else begin
      dec.route = RT_PCI;
    end
  end

endmodule

// File: rtl/brr_route_stage.sv
module brr_route_stage
  import brr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  decision_t         in_dec,
  output logic              loc_valid,
  input  logic              loc_ready,
  output logic              pci_valid,
  input  logic              pci_ready,
  output logic [ADDR_W-1:0] out_addr,
  output decision_t         out_dec
);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  decision_t         dec_q, dec_d;
  logic              accept, retire, to_local, load_en;

  assign in_ready = enable && !busy_q;
  assign accept   = in_valid && in_ready;
  assign to_local = (dec_q.route == RT_LOCAL);
  assign retire   = busy_q && (to_local ? loc_ready : pci_ready);
  assign load_en  = accept;

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    dec_d  = dec_q;
    if (accept) begin
      busy_d = 1'b1;
      addr_d = in_addr;
      dec_d  = in_dec;
    end else if (retire) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dec_q  <= '{route: RT_NONE, miss: 1'b0, cs_boot: 1'b0, cs_split: 1'b0};
    end else if (load_en) begin
      addr_q <= addr_d;
      dec_q  <= dec_d;
    end
  end

  assign loc_valid = busy_q && to_local;
  assign pci_valid = busy_q && !to_local;
  assign out_addr  = addr_q;

  always_comb begin
    out_dec = '{route: RT_NONE, miss: 1'b0, cs_boot: 1'b0, cs_split: 1'b0};
    if (busy_q) out_dec = dec_q;
  end

endmodule

// File: rtl/boot_rom_router.sv
module boot_rom_router
  import brr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_LOG2   = 24,
  parameter int WID_STRAPS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_boot_pci,
  input  logic [WID_STRAPS-1:0] strap_width,
  input  logic                  cfg_we,
  input  logic                  cfg_split_wdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  loc_valid,
  input  logic                  loc_ready,
  output logic [ADDR_W-1:0]     loc_addr,
  output logic                  loc_cs_boot,
  output logic                  loc_cs_split,
  output logic                  pci_valid,
  input  logic                  pci_ready,
  output logic [ADDR_W-1:0]     pci_addr,
  output logic [1:0]            route,
  output logic                  miss,
  output logic                  width_32
);

  logic              captured, boot_pci, split_en;
  decision_t         dec_new, dec_out;
  logic [ADDR_W-1:0] fwd_addr;

  brr_strap_latch #(.WID_STRAPS(WID_STRAPS)) i_straps (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_boot_pci(strap_boot_pci),
    .strap_width   (strap_width),
    .captured      (captured),
    .boot_pci      (boot_pci),
    .width_32      (width_32)
  );

  brr_split_reg i_split (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_split_wdata),
    .split_en(split_en)
  );

  brr_window_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) i_decode (
    .addr_hi (req_addr[ADDR_W-1:WIN_LOG2-1]),
    .boot_pci(boot_pci),
    .split_en(split_en),
    .dec     (dec_new)
  );

  brr_route_stage #(.ADDR_W(ADDR_W)) i_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (captured),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_addr  (req_addr),
    .in_dec   (dec_new),
    .loc_valid(loc_valid),
    .loc_ready(loc_ready),
    .pci_valid(pci_valid),
    .pci_ready(pci_ready),
    .out_addr (fwd_addr),
    .out_dec  (dec_out)
  );

  assign loc_addr     = fwd_addr;
  assign pci_addr     = fwd_addr;
  assign route        = dec_out.route;
  assign miss         = dec_out.miss;
  assign loc_cs_boot  = dec_out.cs_boot;
  assign loc_cs_split = dec_out.cs_split;

endmodule

// File: rtl/brr_checker.sv
module brr_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              loc_valid,
  input logic              loc_ready,
  input logic [ADDR_W-1:0] loc_addr,
  input logic              loc_cs_boot,
  input logic              loc_cs_split,
  input logic              pci_valid,
  input logic              pci_ready,
  input logic [ADDR_W-1:0] pci_addr,
  input logic [1:0]        route,
  input logic              miss,
  input logic              width_32
);

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_valid && pci_valid)); // R7

  AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid && !loc_ready |=> loc_valid && $stable(loc_addr)); // R7

  AST_PCI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && !pci_ready |=> pci_valid && $stable(pci_addr)); // R7

  AST_NO_READY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid || pci_valid) |-> !req_ready); // R7

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_cs_boot, loc_cs_split})); // R4

  AST_CS_ON_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_cs_boot || loc_cs_split) |-> loc_valid && route == 2'b01); // R3

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> route == 2'b00 && !loc_cs_boot && !loc_cs_split && pci_valid); // R5

  AST_WIDTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> $stable(width_32)); // R6

endmodule

bind boot_rom_router brr_checker #(.ADDR_W(ADDR_W)) i_brr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .loc_valid   (loc_valid),
  .loc_ready   (loc_ready),
  .loc_addr    (loc_addr),
  .loc_cs_boot (loc_cs_boot),
  .loc_cs_split(loc_cs_split),
  .pci_valid   (pci_valid),
  .pci_ready   (pci_ready),
  .pci_addr    (pci_addr),
  .route       (route),
  .miss        (miss),
  .width_32    (width_32)
);

// File: tb/test_boot_rom_router.sv
`timescale 1ns/1ps
module test_boot_rom_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_boot_pci;
  logic [1:0]  strap_width;
  logic        cfg_we, cfg_split_wdata;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        loc_valid, loc_ready, loc_cs_boot, loc_cs_split;
  logic [31:0] loc_addr, pci_addr;
  logic        pci_valid, pci_ready;
  logic [1:0]  route;
  logic        miss, width_32;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  boot_rom_router i_boot_rom_router (
    .clk(clk), .rst_n(rst_n),
    .strap_boot_pci(strap_boot_pci), .strap_width(strap_width),
    .cfg_we(cfg_we), .cfg_split_wdata(cfg_split_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_addr(loc_addr),
    .loc_cs_boot(loc_cs_boot), .loc_cs_split(loc_cs_split),
    .pci_valid(pci_valid), .pci_ready(pci_ready), .pci_addr(pci_addr),
    .route(route), .miss(miss), .width_32(width_32)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pick_addr(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'hFEFF_FFFF;
      2: return 32'hFF00_0000;
      3: return 32'hFF7F_FFFF;
      4: return 32'hFF80_0000;
      5: return 32'hFFFF_FFFF;
      6: return 32'hFF3C_5A64;
      default: return 32'h7F80_0000;
    endcase
  endfunction

  task automatic do_reset(input logic boot, input logic [1:0] wid);
    @(negedge clk);
    rst_n = 1'b0;
    strap_boot_pci = boot;
    strap_width = wid;
    repeat (2) @(negedge clk);
    check("R7 ready low in reset", {31'd0, req_ready}, 32'd0);
    check("R6 width zero in reset", {31'd0, width_32}, 32'd0);
    check("R7 no valid in reset", {30'd0, loc_valid, pci_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    strap_boot_pci = ~boot;
    strap_width = ~wid;
    check("R6 width captured", {31'd0, width_32}, {31'd0, |wid});
    check("R7 ready after capture", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic write_split(input logic v);
    cfg_we = 1'b1;
    cfg_split_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Issues one request at a negedge and checks its routing against the model.
  task automatic access(input logic [31:0] a, input logic boot, input logic split,
                        input int stall, input logic [1:0] wid, input logic wr_same,
                        input logic wr_val);
    logic       inwin, lower, is_loc;
    logic [1:0] exp_route;
    logic       exp_cb, exp_cs;
    inwin  = (a[31:24] == 8'hFF);
    lower  = !a[23];
    exp_cb = inwin && !boot;
    exp_cs = inwin && boot && split && lower;
    is_loc = exp_cb || exp_cs;
    exp_route = !inwin ? 2'b00 : (is_loc ? 2'b01 : 2'b10);
    check("R7 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    if (wr_same) begin
      cfg_we = 1'b1;
      cfg_split_wdata = wr_val;
    end
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b0;
    req_addr = ~a;
    if (!inwin) check("R5 miss route", {28'd0, route, miss, loc_cs_boot | loc_cs_split}, {28'd0, 2'b00, 1'b1, 1'b0});
    else if (!boot) check("R4 local boot route", {28'd0, route, loc_cs_boot, loc_cs_split}, {28'd0, exp_route, exp_cb, exp_cs});
    else if (split) check("R3 split route", {28'd0, route, loc_cs_boot, loc_cs_split}, {28'd0, exp_route, exp_cb, exp_cs});
    else check("R2 pci route", {28'd0, route, loc_cs_boot, loc_cs_split}, {28'd0, exp_route, exp_cb, exp_cs});
    check("R1 boot strap held", {30'd0, loc_valid, pci_valid}, {30'd0, is_loc, !is_loc});
    check("R9 address", is_loc ? loc_addr : pci_addr, a);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R7 held while stalled", {29'd0, loc_valid, pci_valid, req_ready}, {29'd0, is_loc, !is_loc, 1'b0});
      check("R7 address held", is_loc ? loc_addr : pci_addr, a);
    end
    check("R6 width held", {31'd0, width_32}, {31'd0, |wid});
    if (is_loc) loc_ready = 1'b1; else pci_ready = 1'b1;
    @(negedge clk);
    loc_ready = 1'b0;
    pci_ready = 1'b0;
    check("R7 retired", {29'd0, loc_valid, pci_valid, req_ready}, 32'd1);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    strap_boot_pci = 1'b0; strap_width = 2'b00;
    cfg_we = 1'b0; cfg_split_wdata = 1'b0;
    req_valid = 1'b0; req_addr = '0;
    loc_ready = 1'b0; pci_ready = 1'b0;

    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 4; w++) begin
        do_reset(b[0], w[1:0]);
        for (int sp = 0; sp < 2; sp++) begin
          if (sp == 1) write_split(1'b1);
          for (int k = 0; k < 8; k++)
            access(pick_addr(k), b[0], sp[0], (k + w) % 3, w[1:0], 1'b0, 1'b0);
        end
      end
    end

    // R8: split resets to 0, and a write on the accept edge does not affect that request.
    do_reset(1'b1, 2'b01);
    access(32'hFF10_0000, 1'b1, 1'b0, 0, 2'b01, 1'b1, 1'b1);
    access(32'hFF10_0004, 1'b1, 1'b1, 1, 2'b01, 1'b0, 1'b0);
    access(32'hFF20_0000, 1'b1, 1'b1, 0, 2'b01, 1'b1, 1'b0);
    access(32'hFF20_0004, 1'b1, 1'b0, 2, 2'b01, 1'b0, 1'b0);
    check("R8 split cleared", {31'd0, route == 2'b00}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule